// File: doc/BRIEF.md
# Single-Cycle 16-bit Processor Core

This block is a small 16-bit processor that fetches one instruction and completes it in every clock cycle. Program and data live in two separate word arrays inside the core. The instruction array is addressed by the program counter. The data array is addressed by a register value. Eight general 16-bit registers feed a function unit that does arithmetic, logic and single-bit shifts. A combinational decoder turns each instruction word into the control signals for the whole core, and a program-counter unit chooses between counting, a relative branch and an absolute jump.

Every instruction word carries a 7-bit opcode in bits 15:9. Bits 15:13 pick the instruction class and bits 12:9 act as the function code. The remaining nine bits hold the destination, the A source and the B source register fields (bits 8:6, 5:3 and 2:0). A 3-bit immediate can take the place of the B field. A 6-bit signed offset can also be made by joining bits 8:6 (upper part) with bits 2:0 (lower part). The test environment preloads the instruction array before it releases reset. It watches progress through the PC output and through a debug port that reads any register combinationally.

Top module: `sc1c_core`

## Requirements
- R1: A synchronous reset sets the PC and all eight registers to zero. While reset is held, no instruction changes any state.
- R2: The instruction at PC uses opcode bits 15:9, DR at 8:6, SA at 5:3 and SB at 2:0. For every instruction other than a taken branch or a jump, the PC advances by exactly one on each clock edge, modulo 2^16.
- R3: Register-source operations write R[DR] from R[SA] and R[SB] with 16-bit wrap. The opcodes are: 0000000 copy A, 0000001 A+1, 0000010 A+B, 0000101 A-B, 0000110 A-1, 0001000 AND, 0001001 OR, 0001010 XOR, 0001011 bitwise NOT of A.
- R4: The opcodes 0001100 (copy), 0001101 (shift right) and 0001110 (shift left) take their operand from R[SB]. Each shift moves by one bit and puts a zero into the vacated bit.
- R5: The opcode 1001100 loads R[DR] with bits 2:0 zero-filled to 16 bits. The opcode 1000010 writes R[SA] plus that zero-filled value.
- R6: The opcode 0010000 loads R[DR] from data word R[SA]. The opcode 0100000 writes R[SB] into data word R[SA]. The data array index is the low bits of R[SA].
- R7: The opcode 1100000 (branch if R[SA] is zero) and the opcode 1100001 (branch if bit 15 of R[SA] is one) set PC to PC plus the sign-extended offset {bits 8:6, bits 2:0} when the condition holds. Otherwise they set PC to PC+1. Neither writes a register.
- R8: The opcode 1110000 loads PC with R[SA] and writes no register.
- R9: Any opcode not listed in R3 to R8 writes no register and no data word, and the PC advances by one.
- R10: A register write lands on the same edge as the PC update. Reads inside the cycle see the old value, so DR may equal SA or SB. R0 is an ordinary writable register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_sel | input | 3 | Register index for the debug read port |
| dbg_data | output | 16 | Combinational value of the selected register |
| pc_out | output | 16 | Current program counter |

## Verification
Assertions in the RTL check four rules on every cycle: the PC steps by one whenever no PC load is decoded, a jump lands on the A-bus value, an untaken branch falls through, and unlisted opcodes produce no write or PC load. The same checks confirm that each register write and each store appears in its target on the next edge. The arithmetic results, the shift fill, the zero-fill of the immediate, the sign of backward branch offsets, and reset in the middle of a program are shown only by the bench. Its behavioural model runs the same program and is compared with the PC and every register after each clock.

// File: rtl/sc1c_pkg.sv
package sc1c_pkg;
  localparam int WORD_W = 16;
  localparam int RSEL_W = 3;
  localparam int NREGS  = 1 << RSEL_W;
  localparam int OFF_W  = 6;

  typedef enum logic [2:0] {
    CLS_ALU   = 3'b000,
    CLS_LOAD  = 3'b001,
    CLS_STORE = 3'b010,
    CLS_IMM   = 3'b100,
    CLS_BRC   = 3'b110,
    CLS_JUMP  = 3'b111
  } iclass_e;

  typedef enum logic [3:0] {
    FN_PASSA = 4'b0000,
    FN_INCA  = 4'b0001,
    FN_ADD   = 4'b0010,
    FN_ADDC  = 4'b0011,
    FN_ADDNB = 4'b0100,
    FN_SUB   = 4'b0101,
    FN_DECA  = 4'b0110,
    FN_PASSA2= 4'b0111,
    FN_AND   = 4'b1000,
    FN_OR    = 4'b1001,
    FN_XOR   = 4'b1010,
    FN_NOTA  = 4'b1011,
    FN_PASSB = 4'b1100,
    FN_SHR   = 4'b1101,
    FN_SHL   = 4'b1110,
    FN_PASSB2= 4'b1111
  } fsel_e;

  typedef struct packed {
    logic [RSEL_W-1:0] wsel;
    logic [RSEL_W-1:0] asel;
    logic [RSEL_W-1:0] bsel;
    logic              use_k;
    fsel_e             fsel;
    logic              from_mem;
    logic              reg_we;
    logic              mem_we;
    logic              pc_ld;
    logic              is_jump;
    logic              on_neg;
    logic              legal;
  } ctl_t;
endpackage

// File: rtl/sc1c_decode.sv
module sc1c_decode
  import sc1c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] ir,
  output ctl_t              ctl
);
  logic [6:0] opc;
  logic [2:0] cls;
  logic [3:0] fn4;
  logic       ok;

  assign opc = ir[15:9];
  assign cls = ir[15:13];
  assign fn4 = ir[12:9];

  always_comb begin
    ok = 1'b0;
    unique case (cls)
      CLS_ALU:   ok = (fn4 inside {4'h0, 4'h1, 4'h2, 4'h5, 4'h6, 4'h8, 4'h9,
                                   4'hA, 4'hB, 4'hC, 4'hD, 4'hE});
      CLS_LOAD:  ok = (opc == 7'b0010000);
      CLS_STORE: ok = (opc == 7'b0100000);
      CLS_IMM:   ok = (opc == 7'b1000010) || (opc == 7'b1001100);
      CLS_BRC:   ok = (opc == 7'b1100000) || (opc == 7'b1100001);
      CLS_JUMP:  ok = (opc == 7'b1110000);
      default:   ok = 1'b0;
    endcase
  end

  always_comb begin
    ctl          = '0;
    ctl.wsel     = ir[8:6];
    ctl.asel     = ir[5:3];
    ctl.bsel     = ir[2:0];
    ctl.legal    = ok;
    ctl.on_neg   = ir[9];
    if (ok) begin
      unique case (cls)
        CLS_ALU:   ctl.reg_we = 1'b1;
        CLS_LOAD:  begin ctl.from_mem = 1'b1; ctl.reg_we = 1'b1; end
        CLS_STORE: ctl.mem_we = 1'b1;
        CLS_IMM:   begin ctl.use_k = 1'b1; ctl.reg_we = 1'b1; end
        CLS_BRC:   ctl.pc_ld = 1'b1;
        CLS_JUMP:  begin ctl.pc_ld = 1'b1; ctl.is_jump = 1'b1; end
        default:   ctl.reg_we = 1'b0;
      endcase
    end
    ctl.fsel = fsel_e'({fn4[3:1], fn4[0] & ~ctl.pc_ld});
  end

  // R9: an unlisted opcode drives no write and no PC load
  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !ctl.legal |-> (!ctl.reg_we && !ctl.mem_we && !ctl.pc_ld));
endmodule

// File: rtl/sc1c_regfile.sv
module sc1c_regfile
  import sc1c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RSEL_W-1:0] wa,
  input  logic [WORD_W-1:0] wd,
  input  logic [RSEL_W-1:0] ra,
  input  logic [RSEL_W-1:0] rb,
  input  logic [RSEL_W-1:0] rd,
  output logic [WORD_W-1:0] qa,
  output logic [WORD_W-1:0] qb,
  output logic [WORD_W-1:0] qd
);
  logic [WORD_W-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                          regs[g] <= '0;
      else if (we && wa == RSEL_W'(g))  regs[g] <= wd;
    end
  end

  assign qa = regs[ra];
  assign qb = regs[rb];
  assign qd = regs[rd];

  // R10: a write is visible on the edge that performs it
  p_write_lands_r10: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[$past(wa)] == $past(wd));
endmodule

// File: rtl/sc1c_funit.sv
module sc1c_funit
  import sc1c_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  fsel_e             fs,
  output logic [WORD_W-1:0] f,
  output logic              neg,
  output logic              zero
);
  always_comb begin
    unique case (fs)
      FN_PASSA, FN_PASSA2: f = a;
      FN_INCA:             f = a + WORD_W'(1);
      FN_ADD:              f = a + b;
      FN_ADDC:             f = a + b + WORD_W'(1);
      FN_ADDNB:            f = a + ~b;
      FN_SUB:              f = a + ~b + WORD_W'(1);
      FN_DECA:             f = a - WORD_W'(1);
      FN_AND:              f = a & b;
      FN_OR:               f = a | b;
      FN_XOR:              f = a ^ b;
      FN_NOTA:             f = ~a;
      FN_SHR:              f = {1'b0, b[WORD_W-1:1]};
      FN_SHL:              f = {b[WORD_W-2:0], 1'b0};
      default:             f = b;
    endcase
  end

  assign neg  = f[WORD_W-1];
  assign zero = (f == '0);
endmodule

// File: rtl/sc1c_pcunit.sv
module sc1c_pcunit
  import sc1c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pc_ld,
  input  logic              is_jump,
  input  logic              on_neg,
  input  logic              neg,
  input  logic              zero,
  input  logic [OFF_W-1:0]  off,
  input  logic [WORD_W-1:0] jaddr,
  output logic [WORD_W-1:0] pc
);
  logic              take;
  logic [WORD_W-1:0] pc_nxt;
  logic [WORD_W-1:0] off_x;

  assign take  = on_neg ? neg : zero;
  assign off_x = {{(WORD_W-OFF_W){off[OFF_W-1]}}, off};

  always_comb begin
    pc_nxt = pc + WORD_W'(1);
    if (pc_ld) begin
      if (is_jump)   pc_nxt = jaddr;
      else if (take) pc_nxt = pc + off_x;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_nxt;
  end

  // R2: no PC load means a step of one
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    !pc_ld |=> pc == $past(pc) + WORD_W'(1));
  // R8: a jump lands on the A-bus value
  p_jump_dest_r8: assert property (@(posedge clk) disable iff (rst)
    (pc_ld && is_jump) |=> pc == $past(jaddr));
  // R7: an untaken branch falls through
  p_fallthru_r7: assert property (@(posedge clk) disable iff (rst)
    (pc_ld && !is_jump && !take) |=> pc == $past(pc) + WORD_W'(1));
endmodule

// File: rtl/sc1c_core.sv
module sc1c_core
  import sc1c_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        dbg_sel,
  output logic [15:0]       dbg_data,
  output logic [15:0]       pc_out
);
  localparam int IAW = $clog2(IMEM_DEPTH);
  localparam int DAW = $clog2(DMEM_DEPTH);

  logic [WORD_W-1:0] imem [IMEM_DEPTH];
  logic [WORD_W-1:0] dmem [DMEM_DEPTH];

  initial begin
    for (int i = 0; i < IMEM_DEPTH; i++) imem[i] = '0;
  end

  logic [WORD_W-1:0] pc, ir, bus_a, rf_b, bus_b, fu_out, mem_q, wr_data;
  logic              fu_neg, fu_zero;
  logic [DAW-1:0]    d_idx;
  ctl_t              ctl;

  assign ir = imem[pc[IAW-1:0]];

  sc1c_decode u_dec (
    .clk (clk), .rst (rst), .ir (ir), .ctl (ctl)
  );

  sc1c_regfile u_rf (
    .clk (clk), .rst (rst),
    .we (ctl.reg_we), .wa (ctl.wsel), .wd (wr_data),
    .ra (ctl.asel), .rb (ctl.bsel), .rd (dbg_sel),
    .qa (bus_a), .qb (rf_b), .qd (dbg_data)
  );

  assign bus_b = ctl.use_k ? {{(WORD_W-3){1'b0}}, ir[2:0]} : rf_b;

  sc1c_funit u_fu (
    .a (bus_a), .b (bus_b), .fs (ctl.fsel),
    .f (fu_out), .neg (fu_neg), .zero (fu_zero)
  );

  assign d_idx   = bus_a[DAW-1:0];
  assign mem_q   = dmem[d_idx];
  assign wr_data = ctl.from_mem ? mem_q : fu_out;

  always_ff @(posedge clk) begin
    if (!rst && ctl.mem_we) dmem[d_idx] <= bus_b;
  end

  sc1c_pcunit u_pc (
    .clk (clk), .rst (rst),
    .pc_ld (ctl.pc_ld), .is_jump (ctl.is_jump), .on_neg (ctl.on_neg),
    .neg (fu_neg), .zero (fu_zero),
    .off ({ir[8:6], ir[2:0]}), .jaddr (bus_a), .pc (pc)
  );

  assign pc_out = pc;

  // R6: a store shows up in the data array on the next edge
  p_store_lands_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.mem_we |=> dmem[$past(d_idx)] == $past(bus_b));
endmodule

// File: tb/sim_sc1c_core.sv
`timescale 1ns/100ps
module sim_sc1c_core;
  localparam int ID = 64;
  localparam int DD = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  dbg_sel = '0;
  logic [15:0] dbg_data, pc_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sc1c_core #(.IMEM_DEPTH(ID), .DMEM_DEPTH(DD)) u0 (
    .clk (clk), .rst (rst), .dbg_sel (dbg_sel),
    .dbg_data (dbg_data), .pc_out (pc_out)
  );

  logic [15:0] prog [ID];
  logic [15:0] m_reg [8];
  logic [15:0] m_mem [DD];
  logic [15:0] m_pc;
  string       last_tag;

  function automatic logic [15:0] ins(input logic [6:0] op, input int d, input int a, input int b);
    return {op, 3'(d), 3'(a), 3'(b)};
  endfunction
  function automatic logic [15:0] brx(input logic [6:0] op, input int a, input int off);
    logic [5:0] o;
    o = 6'(off);
    return {op, o[5:3], 3'(a), o[2:0]};
  endfunction

  function automatic string tag_of(input logic [15:0] w);
    logic [6:0] op;
    op = w[15:9];
    case (op)
      7'b0010000, 7'b0100000: return "R6";
      7'b1100000, 7'b1100001: return "R7";
      7'b1110000:             return "R8";
      7'b1001100, 7'b1000010: return "R5";
      7'b0001100, 7'b0001101, 7'b0001110: return "R4";
      7'b0000000, 7'b0000001, 7'b0000010, 7'b0000101, 7'b0000110,
      7'b0001000, 7'b0001001, 7'b0001010, 7'b0001011:
        return (w[8:6] == 3'd0) ? "R10" : "R3";
      default: return "R9";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_pc = '0;
  endtask

  task automatic model_step();
    logic [15:0] w, a, b, k, nx;
    logic [5:0]  o;
    int d;
    w = prog[m_pc % ID];
    d = int'(w[8:6]);
    a = m_reg[w[5:3]];
    b = m_reg[w[2:0]];
    k = {13'd0, w[2:0]};
    o = {w[8:6], w[2:0]};
    nx = m_pc + 16'd1;
    last_tag = tag_of(w);
    case (w[15:9])
      7'b0000000: m_reg[d] = a;
      7'b0000001: m_reg[d] = a + 16'd1;
      7'b0000010: m_reg[d] = a + b;
      7'b0000101: m_reg[d] = a - b;
      7'b0000110: m_reg[d] = a - 16'd1;
      7'b0001000: m_reg[d] = a & b;
      7'b0001001: m_reg[d] = a | b;
      7'b0001010: m_reg[d] = a ^ b;
      7'b0001011: m_reg[d] = ~a;
      7'b0001100: m_reg[d] = b;
      7'b0001101: m_reg[d] = b >> 1;
      7'b0001110: m_reg[d] = b << 1;
      7'b1001100: m_reg[d] = k;
      7'b1000010: m_reg[d] = a + k;
      7'b0010000: m_reg[d] = m_mem[a % DD];
      7'b0100000: m_mem[a % DD] = b;
      7'b1100000: if (a == 16'd0) nx = m_pc + {{10{o[5]}}, o};
      7'b1100001: if (a[15])      nx = m_pc + {{10{o[5]}}, o};
      7'b1110000: nx = a;
      default: ;
    endcase
    m_pc = nx;
  endtask

  task automatic compare(input string tag);
    n_chk++;
    if (pc_out !== m_pc) begin
      n_bad++;
      $display("FAIL %s pc actual=%h expected=%h", (tag == "R9" || tag == "R7" || tag == "R8") ? tag : "R2", pc_out, m_pc);
    end
    for (int i = 0; i < 8; i++) begin
      dbg_sel = 3'(i);
      #0.5;
      n_chk++;
      if (dbg_data !== m_reg[i]) begin
        n_bad++;
        $display("FAIL %s reg%0d actual=%h expected=%h", tag, i, dbg_data, m_reg[i]);
      end
    end
  endtask

  task automatic run(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(last_tag);
    end
  endtask

  initial begin
    for (int i = 0; i < ID; i++) prog[i] = 16'h0000;
    for (int i = 0; i < DD; i++) m_mem[i] = '0;
    prog[0]  = ins(7'b1001100, 1, 0, 7);  // R5 LDI R1,7
    prog[1]  = ins(7'b1001100, 2, 0, 3);  // LDI R2,3
    prog[2]  = ins(7'b0000010, 3, 1, 2);  // R3 ADD
    prog[3]  = ins(7'b0000101, 4, 2, 1);  // SUB -> negative
    prog[4]  = ins(7'b0000001, 5, 4, 0);  // INC
    prog[5]  = ins(7'b0000110, 6, 0, 0);  // DEC of zero wraps
    prog[6]  = ins(7'b0001000, 7, 1, 2);  // AND
    prog[7]  = ins(7'b0001001, 7, 1, 3);  // OR
    prog[8]  = ins(7'b0001010, 7, 7, 2);  // R10 XOR with DR==SA
    prog[9]  = ins(7'b0001011, 7, 7, 0);  // NOT
    prog[10] = ins(7'b0000000, 6, 3, 0);  // MOVA
    prog[11] = ins(7'b0001100, 5, 0, 2);  // R4 MOVB
    prog[12] = ins(7'b0001110, 5, 0, 4);  // SHL
    prog[13] = ins(7'b0001101, 5, 0, 4);  // SHR zero fill
    prog[14] = ins(7'b1000010, 6, 6, 5);  // ADI
    prog[15] = ins(7'b0100000, 0, 1, 3);  // R6 ST
    prog[16] = ins(7'b0010000, 5, 1, 0);  // LD
    prog[17] = ins(7'b0000011, 7, 1, 2);  // R9 unlisted
    prog[18] = ins(7'b1010000, 7, 1, 2);  // R9 unlisted class
    prog[19] = brx(7'b1100000, 0, 2);     // R7 BRZ taken
    prog[20] = ins(7'b1001100, 7, 0, 1);
    prog[21] = brx(7'b1100000, 1, 5);     // BRZ not taken
    prog[22] = brx(7'b1100001, 4, 2);     // BRN taken
    prog[23] = ins(7'b1001100, 7, 0, 2);
    prog[24] = brx(7'b1100001, 1, 3);     // BRN not taken
    prog[25] = ins(7'b0000010, 2, 3, 3);
    prog[26] = ins(7'b1000010, 2, 2, 7);
    prog[27] = ins(7'b1000010, 2, 2, 3);
    prog[28] = ins(7'b1110000, 0, 2, 0);  // R8 JMP
    prog[29] = ins(7'b1001100, 7, 0, 3);
    prog[30] = ins(7'b0100000, 0, 0, 7);  // ST at R0
    prog[31] = ins(7'b0010000, 0, 0, 0);  // R10 write R0
    prog[32] = brx(7'b1100001, 0, -32);   // backward branch
    #1;
    for (int i = 0; i < ID; i++) u0.imem[i] = prog[i];
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    run(140);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    model_reset();
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    run(25);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule